// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single host requests into pin-level bus cycles for a NAND flash port of 8 or 16 bits. The host selects the cycle type through the window bits of its request address (command, address or data), gives the direction and a byte or halfword, and holds the request until the block acknowledges it. The block then drives one chip enable out of four, the command latch enable (CLE), the address latch enable (ALE), the write and read strobes, and the data output enable. For reads it captures the flash data.

Each cycle has three phases in turn: setup, strobe and hold. The length of each phase is programmable. A separate write-only count holds the data bus in high impedance at the start of a write. An active-low wait input, brought into the clock domain through two flops, lengthens the strobe. Before a data read may assert its strobe, two small delay fields set a minimum quiet gap after CLE and after ALE. All configuration inputs are captured when a request is accepted. A change made while a cycle is running therefore affects only the next cycle.

Top module: `nand_bus_seq`

## Requirements
- R1: The window field is req_addr[WIN_LSB+1:WIN_LSB]. The value 2'b01 gives a command cycle with CLE high for the whole access. The value 2'b10 gives an address cycle with ALE high. The values 2'b00 and 2'b11 give a data cycle with both CLE and ALE low. Command and address cycles are always writes, whatever req_write says.
- R2: Outside an access, and after reset, all chip enables are high, CLE and ALE are low, both strobes are high, the output enable is low, req_ack is low and ack_rdata is zero.
- R3: The setup phase lasts cfg_tset+1 cycles (1 to 256). During setup the chip enable and CLE/ALE are driven and both strobes are high.
- R4: The strobe phase lasts cfg_twait+1 cycles when wait is inactive. Write cycles pulse nand_we_n low and read cycles pulse nand_re_n low, never both at once.
- R5: Every cycle in which the synchronized nand_wait_n is low adds one strobe cycle. The input passes through two flops, so a low level sampled at one clock edge stalls the strobe at the edge two clocks later.
- R6: The hold phase lasts cfg_thold+1 cycles after the strobe ends. req_ack is high for exactly one cycle, the last hold cycle, and all pins are idle in the next cycle.
- R7: On writes, nand_dq_oe stays low for the first cfg_thiz cycles of the access, counted from the first setup cycle. The value 0 means no delay. After that it stays high until the access ends. On reads nand_dq_oe never goes high.
- R8: The strobe of a data read does not start until at least cfg_tclr+1 cycles with CLE low have passed since CLE was last high. Setup is extended to reach this gap.
- R9: In the same way, the strobe of a data read needs at least cfg_tar+1 cycles with ALE low after ALE was last high.
- R10: cfg_bank (0 to 3) selects which single bit of nand_ce_n goes low during an access.
- R11: When cfg_wide is 0 the port is 8 bits wide. The write data driven has bits [15:8] forced to zero, and the returned read data has bits [15:8] forced to zero.
- R12: Read data is captured from nand_dq_in at the clock edge that ends the last strobe cycle. It is presented on ack_rdata with req_ack and held until the next read capture.
- R13: All configuration inputs are sampled when a request is accepted. Changing them during an access does not alter that access.
- R14: nand_dq_out carries the accepted write data while nand_dq_oe is high and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request, held until req_ack |
| req_addr | input | ADDR_W | Host address; window bits select the cycle type |
| req_write | input | 1 | 1 for a data write, 0 for a data read |
| req_wdata | input | DATA_W | Write byte or halfword |
| req_ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | DATA_W | Captured read data |
| cfg_tset | input | TW | Setup count, value plus one cycles |
| cfg_twait | input | TW | Strobe count, value plus one cycles |
| cfg_thold | input | TW | Hold count, value plus one cycles |
| cfg_thiz | input | TW | Write tristate delay, exact cycles |
| cfg_tclr | input | DW | CLE to read strobe gap, value plus one |
| cfg_tar | input | DW | ALE to read strobe gap, value plus one |
| cfg_bank | input | $clog2(NBANK) | Chip enable select |
| cfg_wide | input | 1 | 1 selects the 16-bit port |
| nand_ce_n | output | NBANK | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DATA_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DATA_W | Data bus input value |
| nand_wait_n | input | 1 | Asynchronous wait, active low |

## Verification
The bench uses the default parameters: a 16-bit data path, four chip enables, 8-bit phase counts and 4-bit gap fields. With these values it can reach every chip enable, run both port widths on the same instance, and use gap settings that force setup to stretch well past its programmed count. Because the phase counts are short, accesses with values 0 to 9 finish in a few cycles. This lets the bench cover minimum-length cycles, tristate delays that outlast the strobe, and a wait stall in the middle of the strobe within one short run.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } nbs_phase_e;

  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_CMD  = 2'd1,
    K_ADDR = 2'd2
  } nbs_kind_e;

  // Window field to cycle type: 01 command, 10 address, others data.
  function automatic nbs_kind_e window_kind(input logic [1:0] win);
    case (win)
      2'b01:   window_kind = K_CMD;
      2'b10:   window_kind = K_ADDR;
      default: window_kind = K_DATA;
    endcase
  endfunction

endpackage

// File: rtl/nbs_sync2.sv
module nbs_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= RESET_VAL;
      sync_out <= RESET_VAL;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/nbs_gap_tracker.sv
// Counts cycles since `mark` was last high, saturating at all ones.
// A value of 1 means the mark was high in the previous cycle.
module nbs_gap_tracker #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mark,
  output logic [W-1:0] since
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           since <= TOP;
    else if (mark)        since <= ONE;
    else if (since != TOP) since <= since + ONE;
  end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WIN_LSB = 4,
  parameter int DATA_W  = 16,
  parameter int NBANK   = 4,
  parameter int TW      = 8,
  parameter int DW      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ack,
  output logic [DATA_W-1:0]        ack_rdata,
  input  logic [TW-1:0]            cfg_tset,
  input  logic [TW-1:0]            cfg_twait,
  input  logic [TW-1:0]            cfg_thold,
  input  logic [TW-1:0]            cfg_thiz,
  input  logic [DW-1:0]            cfg_tclr,
  input  logic [DW-1:0]            cfg_tar,
  input  logic [$clog2(NBANK)-1:0] cfg_bank,
  input  logic                     cfg_wide,
  output logic [NBANK-1:0]         nand_ce_n,
  output logic                     nand_cle,
  output logic                     nand_ale,
  output logic                     nand_we_n,
  output logic                     nand_re_n,
  output logic [DATA_W-1:0]        nand_dq_out,
  output logic                     nand_dq_oe,
  input  logic [DATA_W-1:0]        nand_dq_in,
  input  logic                     nand_wait_n
);
  localparam int BANK_W   = $clog2(NBANK);
  localparam int NARROW_W = DATA_W / 2;
  localparam int SINCE_W  = DW + 1;
  localparam logic [TW-1:0] ONE_T = TW'(1);

  // Keeps the low lane only on the narrow port.
  function automatic logic [DATA_W-1:0] lane_fit(input logic [DATA_W-1:0] d,
                                                 input logic wide);
    lane_fit = wide ? d : {{(DATA_W-NARROW_W){1'b0}}, d[NARROW_W-1:0]};
  endfunction

  // Gap met when strictly more than the field value of quiet cycles passed.
  function automatic logic gap_met(input logic [SINCE_W-1:0] since,
                                   input logic [DW-1:0] field);
    gap_met = since > {1'b0, field};
  endfunction

  nbs_phase_e          phase;
  nbs_kind_e           kind_l;
  logic [TW-1:0]       cnt;
  logic [TW-1:0]       hiz_cnt;
  logic [TW-1:0]       twait_l;
  logic [TW-1:0]       thold_l;
  logic [DW-1:0]       tclr_l;
  logic [DW-1:0]       tar_l;
  logic [BANK_W-1:0]   bank_l;
  logic                wide_l;
  logic                write_l;
  logic [DATA_W-1:0]   wdata_l;
  logic [DATA_W-1:0]   rdata_q;
  logic [SINCE_W-1:0]  since_cle;
  logic [SINCE_W-1:0]  since_ale;

  // Named internal events
  logic      active, accept, in_strobe, wait_ok, gap_ok;
  logic      setup_done, strobe_done, hold_done;
  nbs_kind_e req_kind;
  logic      unused_addr_bits;

  assign unused_addr_bits = ^req_addr;
  assign req_kind    = window_kind(req_addr[WIN_LSB+1:WIN_LSB]);
  assign active      = (phase != PH_IDLE);
  assign accept      = (phase == PH_IDLE) && req_valid;
  assign in_strobe   = (phase == PH_STROBE);
  assign gap_ok      = write_l || (gap_met(since_cle, tclr_l) && gap_met(since_ale, tar_l));
  assign setup_done  = (phase == PH_SETUP) && (cnt == '0) && gap_ok;
  assign strobe_done = in_strobe && wait_ok && (cnt == '0);
  assign hold_done   = (phase == PH_HOLD) && (cnt == '0);

  nbs_sync2 #(.RESET_VAL(1'b1)) u_wait_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (nand_wait_n),
    .sync_out (wait_ok)
  );

  nbs_gap_tracker #(.W(SINCE_W)) u_cle_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .mark  (nand_cle),
    .since (since_cle)
  );

  nbs_gap_tracker #(.W(SINCE_W)) u_ale_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .mark  (nand_ale),
    .since (since_ale)
  );

  // Phase sequencing with one shared down-counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      kind_l  <= K_DATA;
      write_l <= 1'b0;
      wdata_l <= '0;
      twait_l <= '0;
      thold_l <= '0;
      tclr_l  <= '0;
      tar_l   <= '0;
      bank_l  <= '0;
      wide_l  <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase   <= PH_SETUP;
            cnt     <= cfg_tset;
            kind_l  <= req_kind;
            write_l <= req_write || (req_kind != K_DATA);
            wdata_l <= lane_fit(req_wdata, cfg_wide);
            twait_l <= cfg_twait;
            thold_l <= cfg_thold;
            tclr_l  <= cfg_tclr;
            tar_l   <= cfg_tar;
            bank_l  <= cfg_bank;
            wide_l  <= cfg_wide;
          end
        end
        PH_SETUP: begin
          if (setup_done) begin
            phase <= PH_STROBE;
            cnt   <= twait_l;
          end else if (cnt != '0) begin
            cnt <= cnt - ONE_T;
          end
        end
        PH_STROBE: begin
          if (strobe_done) begin
            phase <= PH_HOLD;
            cnt   <= thold_l;
            if (!write_l) rdata_q <= lane_fit(nand_dq_in, wide_l);
          end else if (wait_ok) begin
            cnt <= cnt - ONE_T;
          end
        end
        PH_HOLD: begin
          if (hold_done) phase <= PH_IDLE;
          else           cnt   <= cnt - ONE_T;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Write tristate delay, counted from the first setup cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hiz_cnt <= '0;
    else if (accept)                  hiz_cnt <= cfg_thiz;
    else if (active && hiz_cnt != '0) hiz_cnt <= hiz_cnt - ONE_T;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_ce
    assign nand_ce_n[b] = !(active && (bank_l == BANK_W'(b)));
  end

  assign nand_cle    = active && (kind_l == K_CMD);
  assign nand_ale    = active && (kind_l == K_ADDR);
  assign nand_we_n   = !(in_strobe && write_l);
  assign nand_re_n   = !(in_strobe && !write_l);
  assign nand_dq_oe  = active && write_l && (hiz_cnt == '0);
  assign nand_dq_out = nand_dq_oe ? wdata_l : '0;
  assign req_ack     = hold_done;
  assign ack_rdata   = rdata_q;

endmodule

// File: rtl/nand_bus_seq_checker.sv
module nand_bus_seq_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] ce_n,
  input logic             cle,
  input logic             ale,
  input logic             we_n,
  input logic             re_n,
  input logic             oe,
  input logic             ack,
  input logic             in_strobe,
  input logic             wait_ok
);
  a_r10_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);

  a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  a_r4_strobe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !(&ce_n));

  a_r5_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !wait_ok) |=> in_strobe);

  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r6_idle_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (&ce_n));

  a_r7_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !oe);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&ce_n) |-> (!cle && !ale && we_n && re_n && !oe && !ack));
endmodule

bind nand_bus_seq nand_bus_seq_checker #(.NBANK(NBANK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (nand_ce_n),
  .cle       (nand_cle),
  .ale       (nand_ale),
  .we_n      (nand_we_n),
  .re_n      (nand_re_n),
  .oe        (nand_dq_oe),
  .ack       (req_ack),
  .in_strobe (in_strobe),
  .wait_ok   (wait_ok)
);

// File: tb/nand_bus_seq_bench.sv
module nand_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] ack_rdata;
  logic [7:0]  cfg_tset = '0, cfg_twait = '0, cfg_thold = '0, cfg_thiz = '0;
  logic [3:0]  cfg_tclr = '0, cfg_tar = '0;
  logic [1:0]  cfg_bank = '0;
  logic        cfg_wide = 1'b0;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] nand_dq_out;
  logic [15:0] nand_dq_in = 16'hA55A;
  logic        nand_wait_n = 1'b1;

  int n_checks = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  nand_bus_seq u_nand_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_ack(req_ack),
    .ack_rdata(ack_rdata), .cfg_tset(cfg_tset), .cfg_twait(cfg_twait),
    .cfg_thold(cfg_thold), .cfg_thiz(cfg_thiz), .cfg_tclr(cfg_tclr),
    .cfg_tar(cfg_tar), .cfg_bank(cfg_bank), .cfg_wide(cfg_wide),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_wait_n(nand_wait_n)
  );

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_ph, m_el, m_age, m_cyc, m_last_cle, m_last_ale;
  int          m_tset, m_twait, m_thold, m_thiz, m_tclr, m_tar, m_bank, m_kind;
  bit          m_wr, m_wide, m_weff, m_cle_now, m_ale_now;
  logic [15:0] m_wd, m_rd;
  bit          wq[$];

  function automatic logic [15:0] fit(input logic [15:0] d, input bit wide);
    return wide ? d : (d & 16'h00FF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_age = 0; m_cyc = 0;
      m_last_cle = -1000; m_last_ale = -1000;
      m_rd = '0; m_wd = '0; m_wr = 0; m_kind = 0; m_bank = 0;
      wq.delete(); wq.push_back(1'b1); wq.push_back(1'b1);
    end else begin
      m_weff    = wq[wq.size()-2];
      m_cle_now = (m_ph != 0) && (m_kind == 1);
      m_ale_now = (m_ph != 0) && (m_kind == 2);
      if (m_ph != 0) m_age++;
      case (m_ph)
        0: if (req_valid) begin
             m_kind  = (req_addr[5:4] == 2'b01) ? 1 : (req_addr[5:4] == 2'b10) ? 2 : 0;
             m_wr    = req_write || (m_kind != 0);
             m_tset  = cfg_tset;  m_twait = cfg_twait; m_thold = cfg_thold;
             m_thiz  = cfg_thiz;  m_tclr  = cfg_tclr;  m_tar   = cfg_tar;
             m_bank  = cfg_bank;  m_wide  = cfg_wide;
             m_wd    = fit(req_wdata, cfg_wide);
             m_ph = 1; m_el = 0; m_age = 0;
           end
        1: if (m_el >= m_tset &&
               (m_wr || ((m_cyc - m_last_cle) > m_tclr && (m_cyc - m_last_ale) > m_tar))) begin
             m_ph = 2; m_el = 0;
           end else m_el++;
        2: if (m_weff) begin
             if (m_el >= m_twait) begin
               m_ph = 3; m_el = 0;
               if (!m_wr) m_rd = fit(nand_dq_in, m_wide);
             end else m_el++;
           end
        default: if (m_el >= m_thold) m_ph = 0; else m_el++;
      endcase
      if (m_cle_now) m_last_cle = m_cyc;
      if (m_ale_now) m_last_ale = m_cyc;
      wq.push_back(nand_wait_n);
      if (wq.size() > 4) void'(wq.pop_front());
      m_cyc++;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit act_m, oe_m, ack_m;
      logic [3:0] ce_m;
      act_m = (m_ph != 0);
      ce_m  = act_m ? ~(4'b0001 << m_bank) : 4'hF;
      oe_m  = act_m && m_wr && (m_age >= m_thiz);
      ack_m = (m_ph == 3) && (m_el >= m_thold);
      chk("R10", "chip enables", nand_ce_n, ce_m);
      chk("R1", "cle", nand_cle, act_m && m_kind == 1);
      chk("R1", "ale", nand_ale, act_m && m_kind == 2);
      chk("R4", "we_n", nand_we_n, !(m_ph == 2 && m_wr));
      chk("R4", "re_n", nand_re_n, !(m_ph == 2 && !m_wr));
      chk("R7", "dq_oe", nand_dq_oe, oe_m);
      chk("R14", "dq_out", nand_dq_out, oe_m ? m_wd : 16'h0);
      chk("R6", "ack", req_ack, ack_m);
      chk("R12", "ack_rdata", ack_rdata, m_rd);
    end
  end

  // Gap monitor: quiet cycles between CLE/ALE and the next read strobe
  int ncyc = 0, last_cle_n = -1000, last_ale_n = -1000, gap_cle = -1, gap_ale = -1;
  bit prev_re_n = 1'b1;
  always @(negedge clk) begin
    ncyc++;
    if (nand_cle) last_cle_n = ncyc;
    if (nand_ale) last_ale_n = ncyc;
    if (prev_re_n && !nand_re_n) begin
      gap_cle = ncyc - last_cle_n - 1;
      gap_ale = ncyc - last_ale_n - 1;
    end
    prev_re_n = nand_re_n;
  end

  // Read data source changes every cycle so the capture edge matters
  initial forever begin
    @(negedge clk);
    nand_dq_in = nand_dq_in + 16'h1357;
  end

  int          ms_setup, ms_strobe, ms_hold, ms_hiz;
  bit          ms_oe_seen, ms_cle, ms_ale;
  logic [3:0]  ms_ce;
  logic [15:0] ms_dq, ms_rdata;

  task automatic set_cfg(input int ts, input int tw, input int th, input int tz,
                         input int tc, input int ta, input int bk, input bit wd);
    cfg_tset = 8'(ts); cfg_twait = 8'(tw); cfg_thold = 8'(th); cfg_thiz = 8'(tz);
    cfg_tclr = 4'(tc); cfg_tar = 4'(ta); cfg_bank = 2'(bk); cfg_wide = wd;
  endtask

  task automatic do_access(input logic [7:0] a, input bit wr, input logic [15:0] wd);
    bit strobed;
    ms_setup = 0; ms_strobe = 0; ms_hold = 0; ms_hiz = 0;
    ms_oe_seen = 0; ms_cle = 0; ms_ale = 0; ms_ce = 4'hF; ms_dq = '0;
    strobed = 0;
    @(negedge clk);
    req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    do begin
      @(negedge clk);
      if (nand_ce_n != 4'hF) begin
        ms_ce = nand_ce_n;
        if (nand_cle) ms_cle = 1;
        if (nand_ale) ms_ale = 1;
        if (nand_dq_oe && !ms_oe_seen) begin ms_oe_seen = 1; ms_dq = nand_dq_out; end
        if (!ms_oe_seen) ms_hiz++;
        if (!nand_we_n || !nand_re_n) begin strobed = 1; ms_strobe++; end
        else if (!strobed) ms_setup++;
        else ms_hold++;
      end
    end while (!req_ack);
    req_valid = 1'b0;
    ms_rdata = ack_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: idle pins after reset
    chk("R2", "idle ce_n", nand_ce_n, 4'hF);
    chk("R2", "idle strobes", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 5'b11000);
    chk("R2", "idle ack/rdata", {req_ack, ack_rdata}, 17'h0);

    // Command write: phase lengths R3 R4 R6, window R1
    set_cfg(2, 3, 1, 0, 0, 0, 0, 0);
    do_access(8'h10, 1'b0, 16'h0090);
    chk("R3", "setup length", ms_setup, 3);
    chk("R4", "strobe length", ms_strobe, 4);
    chk("R6", "hold length incl ack", ms_hold, 2);
    chk("R1", "cmd forced write/cle", {ms_cle, ms_ale, ms_oe_seen}, 3'b101);

    // Address write on bank 2 with tristate delay R7 R10
    set_cfg(2, 3, 1, 3, 0, 0, 2, 0);
    do_access(8'h20, 1'b0, 16'h0033);
    chk("R7", "write hi-z cycles", ms_hiz, 3);
    chk("R10", "bank 2 enable", ms_ce, 4'b1011);
    chk("R1", "addr cycle ale", {ms_cle, ms_ale}, 2'b01);

    // Narrow then wide data writes R11 R14
    set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
    do_access(8'h00, 1'b1, 16'hBEEF);
    chk("R11", "narrow write lanes", ms_dq, 16'h00EF);
    set_cfg(1, 1, 0, 0, 0, 0, 0, 1);
    do_access(8'h00, 1'b1, 16'hBEEF);
    chk("R14", "wide write data", ms_dq, 16'hBEEF);

    // CLE-to-read gap R8
    set_cfg(0, 0, 0, 0, 5, 0, 0, 0);
    do_access(8'h10, 1'b1, 16'h0070);
    do_access(8'h00, 1'b0, 16'h0);
    chk("R8", "cle to re gap", gap_cle, 6);
    chk("R7", "read never drives", ms_oe_seen, 0);

    // ALE-to-read gap R9
    set_cfg(0, 0, 0, 0, 0, 9, 0, 0);
    do_access(8'h20, 1'b1, 16'h0001);
    do_access(8'h00, 1'b0, 16'h0);
    chk("R9", "ale to re gap", gap_ale, 10);

    // Wait stretch R5 on a wide read
    set_cfg(1, 5, 0, 0, 0, 0, 1, 1);
    fork
      do_access(8'h00, 1'b0, 16'h0);
      begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        nand_wait_n = 1'b0;
        repeat (3) @(negedge clk);
        nand_wait_n = 1'b1;
      end
    join
    chk("R5", "strobe with 3 wait cycles", ms_strobe, 9);
    held = ms_rdata;

    // Config change mid-access R13, read data held R12
    set_cfg(1, 4, 2, 0, 0, 0, 1, 1);
    fork
      do_access(8'h00, 1'b1, 16'h1234);
      begin
        @(negedge clk);
        repeat (2) @(negedge clk);
        set_cfg(6, 0, 0, 9, 15, 15, 3, 0);
      end
    join
    chk("R13", "setup kept", ms_setup, 2);
    chk("R13", "strobe kept", ms_strobe, 5);
    chk("R13", "hold kept", ms_hold, 3);
    chk("R13", "bank kept", ms_ce, 4'b1101);
    chk("R12", "read data held over write", ack_rdata, held);

    // Window 11 is data, narrow read lanes R1 R11
    set_cfg(2, 2, 1, 0, 0, 0, 0, 0);
    do_access(8'h30, 1'b0, 16'h0);
    chk("R1", "window 11 is data", {ms_cle, ms_ale}, 2'b00);
    chk("R11", "narrow read upper byte", ms_rdata[15:8], 8'h00);

    // Minimum counts on bank 3 R3 R4 R6 R10
    set_cfg(0, 0, 0, 0, 0, 0, 3, 1);
    do_access(8'h00, 1'b1, 16'hC0DE);
    chk("R3", "minimum setup", ms_setup, 1);
    chk("R4", "minimum strobe", ms_strobe, 1);
    chk("R6", "minimum hold", ms_hold, 1);
    chk("R10", "bank 3 enable", ms_ce, 4'b0111);

    repeat (3) @(negedge clk);
    chk("R2", "idle after last access", nand_ce_n, 4'hF);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule